// File: doc/BRIEF.md
# PPM-Trimmed Periodic Tick Generator

This block turns a free-running crystal clock into a steady stream of one-cycle tick pulses at a nominal rate (10 Hz by default). The input frequency is rarely an exact multiple of the tick rate. A base divider therefore produces periods of either the whole quotient or one cycle more, chosen by a remainder accumulator, so that the long-run tick rate is exact.

Crystal error is corrected by a signed trim in parts per million. The trim is captured from a parallel input while reset is held. A serial divider then converts it into a trim interval of one million divided by the trim magnitude. A trim counter runs alongside the base divider. Each time it reaches that interval, the tick period in progress gains or loses one input cycle, and the tick that closes that period raises a corrected flag.

Top module: `trim_tick_gen`

## Requirements
- R1: With no trim, the first tick period lasts BASE = CLK_HZ / TICK_HZ cycles. Period j (j >= 1) lasts BASE cycles, plus one when floor(j*REM/TICK_HZ) exceeds floor((j-1)*REM/TICK_HZ), where REM = CLK_HZ mod TICK_HZ.
- R2: While reset is held, tick_o and corr_o are low. The first tick_o pulse is visible after the BASE-th rising edge that follows reset release, and every tick_o pulse lasts exactly one cycle.
- R3: For a nonzero trim of magnitude m, the trim interval is I = floor(1000000 / m) input cycles. Trim events occur on the I-th, 2I-th, 3I-th, ... rising edge after reset release.
- R4: A positive trim makes each trim event shorten the tick period in progress by one input cycle.
- R5: A negative trim makes each trim event lengthen the tick period in progress by one input cycle.
- R6: A positive-trim event that lands on the final cycle of a period leaves that period at its nominal length and shortens the following period by one cycle instead.
- R7: corr_o is high for exactly the cycle of the tick that closes a period whose length was changed by a trim event, and it is never high without tick_o.
- R8: A trim of zero disables correction: corr_o stays low and every period follows R1.
- R9: A trim magnitude above 1000 is treated as 1000, in either sign.
- R10: trim_i is sampled only while reset is held. Changes to it after release have no effect on tick timing or on corr_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal-derived input clock |
| rst | input | 1 | Synchronous active-high reset; trim_i is captured while it is high |
| trim_i | input | TRIM_W | Signed trim in ppm (two's complement) |
| tick_o | output | 1 | One-cycle tick pulse at the nominal tick rate |
| corr_o | output | 1 | High with tick_o when the closing period was trimmed |

## Verification
The checks on period length assume that BASE exceeds the number of trim events that can fall into one period by at least two. They also assume that the trim interval is longer than the roughly twenty cycles the interval divider needs after reset. Together these keep every period at two cycles or more and ensure the first trim event finds a settled interval. The stimulus uses a 1005 Hz clock with a 10 Hz tick, giving a base of 100 and a remainder of 5, and trim magnitudes between 500 and 2000 ppm, so intervals are at least 1000 cycles. trim_i is changed only while reset is high and is then deliberately scrambled after release.

// File: rtl/ttg_pkg.sv
package ttg_pkg;

    // How far the period counter advances on one input cycle.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_ONE  = 2'd1,
        STEP_SKIP = 2'd2
    } step_e;

    function automatic step_e trim_step(input logic evt, input logic fast);
        if (!evt)      return STEP_ONE;
        else if (fast) return STEP_SKIP;
        else           return STEP_HOLD;
    endfunction

endpackage

// File: rtl/trim_interval_ctl.sv
module trim_interval_ctl #(
    parameter int TRIM_W    = 12,
    parameter int MAX_PPM   = 1000,
    parameter int PPM_SCALE = 1000000,
    localparam int MW = $clog2(MAX_PPM + 1),
    localparam int QW = $clog2(PPM_SCALE + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TRIM_W-1:0] trim_i,
    output logic                     evt_o,
    output logic                     fast_o,
    output logic [QW-1:0]            interval_o,
    output logic                     ready_o
);
    localparam int IXW = $clog2(QW);
    localparam logic [QW-1:0] SCALE_V = QW'(PPM_SCALE);

    typedef struct packed {
        logic           en;
        logic           fast;
        logic [MW-1:0]  mag;
        logic [MW:0]    rem;
        logic [QW-1:0]  quo;
        logic [IXW-1:0] idx;
        logic           busy;
        logic           ready;
        logic [QW-1:0]  tcnt;
    } ctl_t;

    ctl_t cur_q, nxt_d, init_d;

    logic [TRIM_W:0] ext, absv;
    logic [MW+1:0]   trial;
    logic            hit;

    // Capture value presented while reset is held.
    always_comb begin
        ext  = {trim_i[TRIM_W-1], trim_i};
        absv = trim_i[TRIM_W-1] ? (~ext + (TRIM_W+1)'(1)) : ext;
        init_d       = '0;
        init_d.mag   = (absv > (TRIM_W+1)'(MAX_PPM)) ? MW'(MAX_PPM) : MW'(absv);
        init_d.en    = (absv != '0);
        init_d.fast  = ~trim_i[TRIM_W-1];
        init_d.idx   = IXW'(QW - 1);
        init_d.busy  = (absv != '0);
    end

    always_comb begin
        nxt_d = cur_q;
        trial = {cur_q.rem, SCALE_V[cur_q.idx]};
        hit   = cur_q.en && cur_q.ready && (cur_q.tcnt >= cur_q.quo - QW'(1));

        // Restoring division, one quotient bit per cycle, MSB first.
        if (cur_q.busy) begin
            if (trial >= {2'b00, cur_q.mag}) begin
                nxt_d.rem = (MW+1)'(trial - {2'b00, cur_q.mag});
                nxt_d.quo[cur_q.idx] = 1'b1;
            end else begin
                nxt_d.rem = (MW+1)'(trial);
            end
            if (cur_q.idx == '0) begin
                nxt_d.busy  = 1'b0;
                nxt_d.ready = 1'b1;
            end else begin
                nxt_d.idx = cur_q.idx - IXW'(1);
            end
        end

        // Trim interval counter, running from the first edge after reset.
        if (cur_q.en) begin
            nxt_d.tcnt = hit ? '0 : cur_q.tcnt + QW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= init_d;
        else     cur_q <= nxt_d;
    end

    assign evt_o      = hit;
    assign fast_o     = cur_q.fast;
    assign interval_o = cur_q.quo;
    assign ready_o    = cur_q.ready;

endmodule

// File: rtl/tick_period_gen.sv
module tick_period_gen
    import ttg_pkg::*;
#(
    parameter int CLK_HZ  = 32768,
    parameter int TICK_HZ = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic fast_i,
    output logic tick_o,
    output logic corr_o
);
    localparam int BASE = CLK_HZ / TICK_HZ;
    localparam int REM  = CLK_HZ % TICK_HZ;
    localparam int CW   = $clog2(BASE + 2);
    localparam int AW   = $clog2(2 * TICK_HZ);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [AW-1:0] acc;
        logic          adj;
        logic          tick;
        logic          corr;
    } per_t;

    per_t  cur_q, nxt_d;
    step_e step;
    logic  done, leftover, longp;
    logic [AW-1:0] sum;
    logic [CW-1:0] len;

    always_comb begin
        nxt_d    = cur_q;
        step     = trim_step(evt_i, fast_i);
        done     = CW'(step) > cur_q.cnt;
        leftover = (cur_q.cnt == '0) && (step == STEP_SKIP);
        sum      = cur_q.acc + AW'(REM);
        longp    = sum >= AW'(TICK_HZ);
        len      = CW'(BASE) + CW'(longp);

        if (done) begin
            nxt_d.acc  = longp ? sum - AW'(TICK_HZ) : sum;
            nxt_d.cnt  = len - CW'(1) - CW'(leftover);
            nxt_d.tick = 1'b1;
            nxt_d.corr = cur_q.adj | (evt_i & ~leftover);
            nxt_d.adj  = leftover;
        end else begin
            nxt_d.cnt  = cur_q.cnt - CW'(step);
            nxt_d.adj  = cur_q.adj | evt_i;
            nxt_d.tick = 1'b0;
            nxt_d.corr = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q      <= '0;
            cur_q.cnt  <= CW'(BASE - 1);
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign tick_o = cur_q.tick;
    assign corr_o = cur_q.corr;

endmodule

// File: rtl/trim_tick_gen.sv
module trim_tick_gen #(
    parameter int CLK_HZ    = 32768,
    parameter int TICK_HZ   = 10,
    parameter int TRIM_W    = 12,
    parameter int MAX_PPM   = 1000,
    parameter int PPM_SCALE = 1000000
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [TRIM_W-1:0] trim_i,
    output logic                     tick_o,
    output logic                     corr_o
);
    localparam int IVL_W = $clog2(PPM_SCALE + 1);

    logic             trim_ovf;
    logic             trim_fast;
    logic [IVL_W-1:0] interval;
    logic             interval_ready;

    trim_interval_ctl #(
        .TRIM_W   (TRIM_W),
        .MAX_PPM  (MAX_PPM),
        .PPM_SCALE(PPM_SCALE)
    ) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .trim_i    (trim_i),
        .evt_o     (trim_ovf),
        .fast_o    (trim_fast),
        .interval_o(interval),
        .ready_o   (interval_ready)
    );

    tick_period_gen #(
        .CLK_HZ (CLK_HZ),
        .TICK_HZ(TICK_HZ)
    ) u_per (
        .clk   (clk),
        .rst   (rst),
        .evt_i (trim_ovf),
        .fast_i(trim_fast),
        .tick_o(tick_o),
        .corr_o(corr_o)
    );

endmodule

// File: rtl/trim_tick_gen_chk.sv
module trim_tick_gen_chk #(
    parameter int BASE    = 3276,
    parameter int MIN_IVL = 1000,
    parameter int IW      = 20
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_o,
    input logic          corr_o,
    input logic          ovf,
    input logic [IW-1:0] interval,
    input logic          ready
);
    localparam int MAXADJ = BASE / MIN_IVL + 2;

    int gap_q;

    always_ff @(posedge clk) begin
        if (rst)         gap_q <= 0;
        else if (tick_o) gap_q <= 1;
        else             gap_q <= gap_q + 1;
    end

    // R2
    tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

    // R7
    corr_with_tick_chk: assert property (@(posedge clk) disable iff (rst)
        corr_o |-> tick_o);

    // R1
    nominal_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && !corr_o) |-> (gap_q == BASE || gap_q == BASE + 1));

    // R4
    corrected_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick_o && corr_o) |-> (gap_q >= BASE - MAXADJ && gap_q <= BASE + MAXADJ));

    // R3
    ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
        ovf |=> !ovf);

    // R10
    interval_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ready |=> (ready && $stable(interval)));

endmodule

bind trim_tick_gen trim_tick_gen_chk #(
    .BASE   (CLK_HZ / TICK_HZ),
    .MIN_IVL(PPM_SCALE / MAX_PPM),
    .IW     (IVL_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .tick_o  (tick_o),
    .corr_o  (corr_o),
    .ovf     (trim_ovf),
    .interval(interval),
    .ready   (interval_ready)
);

// File: tb/sim_trim_tick_gen.sv
module sim_trim_tick_gen;
    localparam int CLK_HZ  = 1005;
    localparam int TICK_HZ = 10;
    localparam int TRIM_W  = 12;
    localparam int BASE    = CLK_HZ / TICK_HZ;
    localparam int REM     = CLK_HZ % TICK_HZ;
    localparam int NCFG    = 10;

    // Stimulus table: captured trim, cycles to run, requirement tag number.
    localparam int CFG_TRIM [NCFG] = '{0,    0,    1000, -1000, 997,  996,  -996, 2000, -1500, 500};
    localparam int CFG_CYC  [NCFG] = '{2500, 2000, 5000, 5000,  4000, 5000, 5000, 3000, 3000,  4500};
    localparam int CFG_TAG  [NCFG] = '{1,    8,    4,    5,     3,    6,    5,    9,    9,     10};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic signed [TRIM_W-1:0] trim_i = '0;
    logic tick_o, corr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    trim_tick_gen #(
        .CLK_HZ (CLK_HZ),
        .TICK_HZ(TICK_HZ),
        .TRIM_W (TRIM_W)
    ) u0 (
        .clk   (clk),
        .rst   (rst),
        .trim_i(trim_i),
        .tick_o(tick_o),
        .corr_o(corr_o)
    );

    function automatic string tag_name(input int n);
        case (n)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int period_len(input int j);
        if (j == 0) return BASE;
        return BASE + ((j * REM) / TICK_HZ - ((j - 1) * REM) / TICK_HZ);
    endfunction

    task automatic run_cfg(input int k);
        int trim, mag, ivl, s, eff, nxt, j;
        bit pend, o, ovr, exp_t, exp_c;
        string tg;
        trim = CFG_TRIM[k];
        mag  = (trim < 0) ? -trim : trim;
        if (mag > 1000) mag = 1000;               // R9 clamp
        ivl  = (mag == 0) ? 0 : 1000000 / mag;    // R3 interval
        s    = (trim > 0) ? 1 : -1;               // R4 shrink, R5 stretch

        rst    = 1'b1;
        trim_i = TRIM_W'(trim);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: outputs low during reset
        checks++;
        if (tick_o !== 1'b0 || corr_o !== 1'b0) begin
            fails++;
            $display("FAIL R2 reset state: actual tick=%b corr=%b expected 0 0", tick_o, corr_o);
        end
        rst    = 1'b0;
        // R10: scramble the input after release
        trim_i = (trim == 0) ? TRIM_W'(1000) : '0;

        eff = 0; nxt = BASE; j = 0; pend = 1'b0;
        for (int t = 0; t < CFG_CYC[k]; t++) begin
            @(posedge clk);
            @(negedge clk);
            o   = (ivl != 0) && (((t + 1) % ivl) == 0);
            eff = eff + 1 + (o ? s : 0);
            exp_t = (eff >= nxt);
            exp_c = 1'b0;
            if (exp_t) begin
                ovr   = o && (s == 1) && (eff > nxt);   // R6 carry into next period
                exp_c = pend || (o && !ovr);
                pend  = ovr;
                j++;
                nxt += period_len(j);
            end else if (o) begin
                pend = 1'b1;
            end
            checks++;
            if (tick_o !== exp_t || corr_o !== exp_c) begin
                fails++;
                if (corr_o !== exp_c)  tg = "R7";
                else if (j <= 1 && t < 2 * BASE) tg = "R2";
                else                   tg = tag_name(CFG_TAG[k]);
                $display("FAIL %s trim=%0d cycle=%0d: actual tick=%b corr=%b expected tick=%b corr=%b",
                         tg, trim, t, tick_o, corr_o, exp_t, exp_c);
            end
        end
    endtask

    initial begin
        for (int k = 0; k < NCFG; k++) run_cfg(k);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R2 watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule